// File: doc/BRIEF.md
# Reloadable Down-Counter Baud Timer

This block is a small down-counting timer that produces a periodic single-cycle underflow strobe, which a serial shifter uses as its bit clock. Software sets a base (reload) value and a mode word through a simple register port. The mode word holds an enable bit, a load bit and a two-bit tick-source selector. One of several prescaled tick strobes, each one system-clock cycle wide, is picked by the selector. While the timer is enabled, every selected tick steps the counter down by one.

When a selected tick arrives with the counter at zero, the counter takes the base value again and the underflow strobe goes high for one cycle. The strobe period is therefore the base value plus one selected ticks. A separate load bit copies the base value into the counter while the timer is being prepared, so the first period is exact. To protect a count in progress, software cannot switch the tick source while the timer is enabled.

Top module: `baud_down_timer`

## Requirements
- R1: After synchronous reset the mode word, base value and counter all read as zero, and the underflow strobe is low.
- R2: The register port decodes address 0 as the mode word, address 1 as the base value and address 2 as the counter, which is read-only. Address 3 reads zero. In the mode word, bit 7 is enable, bit 6 is load and bits 1:0 are the tick-source selector. Bits 5:2 of the mode word read as zero.
- R3: While load is 1, the counter copies the base value on every cycle, whatever enable and the ticks do, and no underflow strobe is produced.
- R4: With enable 1 and load 0, each selected tick decrements a nonzero counter by exactly one. Ticks on inputs that are not selected leave the counter unchanged.
- R5: A selected tick that finds the counter at zero reloads the base value and raises the underflow strobe for exactly one cycle, in the cycle after that clock edge. With a tick on every cycle, the first strobe after a load comes base+1 ticks after enabling, for every base value.
- R6: With enable 0, the counter holds its value and the underflow strobe stays low.
- R7: Selector code 00 chooses tick input 0, the oscillator divided by four. Codes 01, 10 and 11 choose tick inputs 1, 2 and 3.
- R8: A mode write made while enable is 1 that changes the selector is discarded entirely, and counting continues undisturbed. A mode write made while enabled that keeps the selector is accepted.
- R9: A write to the base value while the timer runs does not change the counter until the next reload, which then uses the new value.
- R10: Counting starts with the first selected tick in the cycle after the write that sets enable. A tick in the same cycle as that write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src | input | NUM_SRC | Prescaled tick strobes, one cycle wide each; input 0 is the oscillator divided by four |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 8 | Register read data, combinational from reg_raddr |
| uflow | output | 1 | One-cycle underflow strobe to the serial shifter |

## Verification
The bench builds the timer with its default 8-bit counter and four tick sources. At that width the full range of base values is small enough to sweep, so the strobe period is measured against base+1 for all 256 bases, including base zero, where a strobe arrives on every tick. Four sources also keep the whole selector-by-input matrix cheap, so every selector code is checked against ticks on every input. Directed sequences cover load dominating enable, the discarded source switch, a base write during a run, and the tick that coincides with the enabling write.

// File: rtl/btmr_pkg.sv
package btmr_pkg;

    // Register port data width; the mode field positions are fixed by it.
    localparam int REG_W      = 8;
    localparam int SEL_W      = 2;
    localparam int MAX_SRC    = 1 << SEL_W;
    localparam int EN_BIT     = 7;
    localparam int LD_BIT     = 6;

    typedef enum logic [1:0] {
        ADDR_MODE  = 2'd0,
        ADDR_BASE  = 2'd1,
        ADDR_COUNT = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             en;
        logic             ld;
        logic [SEL_W-1:0] sel;
    } mode_t;

    function automatic mode_t mode_unpack(input logic [REG_W-1:0] w);
        mode_t m;
        m.en  = w[EN_BIT];
        m.ld  = w[LD_BIT];
        m.sel = w[SEL_W-1:0];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] mode_pack(input mode_t m);
        logic [REG_W-1:0] w;
        w              = '0;
        w[EN_BIT]      = m.en;
        w[LD_BIT]      = m.ld;
        w[SEL_W-1:0]   = m.sel;
        return w;
    endfunction

endpackage

// File: rtl/btmr_tick_sel.sv
module btmr_tick_sel
    import btmr_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);

    logic [MAX_SRC-1:0] hit;

    for (genvar c = 0; c < MAX_SRC; c++) begin : g_src
        if (c < NUM_SRC) begin : g_live
            assign hit[c] = tick_i[c] && (sel_i == SEL_W'(c));
        end else begin : g_dead
            assign hit[c] = 1'b0;
        end
    end

    assign tick_o = |hit;

endmodule

// File: rtl/btmr_mode_reg.sv
module btmr_mode_reg
    import btmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output mode_t            mode_o
);

    mode_t mode_q;
    mode_t mode_new;
    logic  sel_locked;
    logic  unused_pad;

    assign mode_new   = mode_unpack(wdata_i);
    assign unused_pad = ^wdata_i[LD_BIT-1:SEL_W];
    // A running timer refuses any write that would move its tick source.
    assign sel_locked = mode_q.en && (mode_new.sel != mode_q.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we_i && !sel_locked) begin
            mode_q <= mode_new;
        end
    end

    assign mode_o = mode_q;

    // R8
    sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && mode_q.en && (wdata_i[SEL_W-1:0] != mode_q.sel)) |=> (mode_o == $past(mode_o)));

endmodule

// File: rtl/btmr_counter.sv
module btmr_counter
    import btmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             ld_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] base_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uflow_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             uflow_q;
    logic             step;
    logic             at_zero;

    assign step    = en_i && !ld_i && tick_i;
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            uflow_q <= 1'b0;
        end else begin
            uflow_q <= 1'b0;
            if (ld_i) begin
                cnt_q <= base_i;
            end else if (step) begin
                if (at_zero) begin
                    cnt_q   <= base_i;
                    uflow_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign uflow_o = uflow_q;

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> (cnt_o == $past(base_i)) && !uflow_o);

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !ld_i && tick_i && (cnt_o != '0)) |=> (cnt_o == $past(cnt_o) - 1'b1));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        uflow_o |-> (cnt_o == $past(base_i)) && ($past(cnt_o) == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !ld_i) |=> $stable(cnt_o) && !uflow_o);

endmodule

// File: rtl/baud_down_timer.sv
module baud_down_timer
    import btmr_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               reg_we,
    input  logic [1:0]         reg_waddr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [1:0]         reg_raddr,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               uflow
);

    mode_t            mode;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt;
    logic             tick_sel;
    logic             we_mode;
    logic             we_base;
    logic [REG_W-1:0] base_ext;
    logic [REG_W-1:0] cnt_ext;

    assign we_mode = reg_we && (reg_addr_e'(reg_waddr) == ADDR_MODE);
    assign we_base = reg_we && (reg_addr_e'(reg_waddr) == ADDR_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (we_base) begin
            base_q <= reg_wdata[CNT_W-1:0];
        end
    end

    btmr_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we_mode),
        .wdata_i (reg_wdata),
        .mode_o  (mode)
    );

    btmr_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .tick_i (tick_src),
        .sel_i  (mode.sel),
        .tick_o (tick_sel)
    );

    btmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en_i    (mode.en),
        .ld_i    (mode.ld),
        .tick_i  (tick_sel),
        .base_i  (base_q),
        .cnt_o   (cnt),
        .uflow_o (uflow)
    );

    always_comb begin
        base_ext             = '0;
        base_ext[CNT_W-1:0]  = base_q;
        cnt_ext              = '0;
        cnt_ext[CNT_W-1:0]   = cnt;
        case (reg_addr_e'(reg_raddr))
            ADDR_MODE:  reg_rdata = mode_pack(mode);
            ADDR_BASE:  reg_rdata = base_ext;
            ADDR_COUNT: reg_rdata = cnt_ext;
            default:    reg_rdata = '0;
        endcase
    end

    // R2
    mode_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_e'(reg_raddr) == ADDR_MODE) |-> (reg_rdata[LD_BIT-1:SEL_W] == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0) && !uflow);

endmodule

// File: tb/baud_down_timer_tb.sv
`timescale 1ns/1ps
module baud_down_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tick_src = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_waddr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       uflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    baud_down_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_src  (tick_src),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .uflow     (uflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int s);
        tick_src[s] = 1'b1;
        @(negedge clk);
        tick_src = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int exp;
        int k;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, d); check("R1 mode", d, 0);
        rd(1, d); check("R1 base", d, 0);
        rd(2, d); check("R1 count", d, 0);
        check("R1 uflow", uflow, 0);

        // R2: layout, pad bits, unused address
        wr(0, 8'hFF);
        rd(0, d); check("R2 mode readback", d, 8'hC3);
        rd(3, d); check("R2 addr3", d, 0);

        // R3: load dominates enable
        wr(1, 8'h2A);
        @(negedge clk);
        rd(2, d); check("R3 load copy", d, 8'h2A);
        for (int i = 0; i < 4; i++) begin
            pulse(3);
            rd(2, d); check("R3 hold under ticks", d, 8'h2A);
            check("R3 no uflow", uflow, 0);
        end
        wr(1, 8'h00);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            pulse(3);
            check("R3 base0 no uflow", uflow, 0);
        end

        // R8: select change while enabled discarded, same select accepted
        wr(0, 8'h00);
        rd(0, d); check("R8 discard", d, 8'hC3);
        wr(0, 8'h03);
        rd(0, d); check("R8 same sel accepted", d, 8'h03);
        wr(0, 8'h00);
        rd(0, d); check("R8 disabled change", d, 8'h00);

        // R6: disabled timer holds
        wr(1, 8'd9);
        wr(0, 8'h40);
        @(negedge clk);
        wr(0, 8'h00);
        for (int i = 0; i < 3; i++) begin
            pulse(0);
            rd(2, d); check("R6 hold", d, 9);
            check("R6 no uflow", uflow, 0);
        end

        // R4 / R7: selector against every input
        wr(1, 8'd10);
        for (int sel = 0; sel < 4; sel++) begin
            wr(0, 8'h40 | 8'(sel));
            @(negedge clk);
            wr(0, 8'h80 | 8'(sel));
            exp = 10;
            for (int s = 0; s < 4; s++) begin
                pulse(s);
                if (s == sel) exp--;
                rd(2, d); check("R4 R7 select matrix", d, exp);
            end
            wr(0, 8'(sel));
        end
        wr(0, 8'h00);

        // R10: tick coincident with the enabling write
        wr(1, 8'd5);
        wr(0, 8'h40);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 2'd0; reg_wdata = 8'h80; tick_src[0] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_src = '0;
        rd(2, d); check("R10 same-cycle tick ignored", d, 5);
        pulse(0);
        rd(2, d); check("R10 first tick counts", d, 4);

        // R9: base write during a run
        wr(1, 8'd7);
        rd(2, d); check("R9 count undisturbed", d, 4);
        for (int i = 3; i >= 0; i--) begin
            pulse(0);
            rd(2, d); check("R9 count down", d, i);
            check("R9 no early uflow", uflow, 0);
        end
        pulse(0);
        rd(2, d); check("R9 reload new base", d, 7);
        check("R5 uflow high", uflow, 1);
        @(negedge clk);
        check("R5 uflow one cycle", uflow, 0);

        // R8: source switch while running is discarded, counting goes on
        wr(0, 8'h82);
        rd(0, d); check("R8 running discard", d, 8'h80);
        pulse(0);
        rd(2, d); check("R8 count continues", d, 6);
        pulse(2);
        rd(2, d); check("R8 old source kept", d, 6);
        wr(0, 8'h00);

        // R5: period sweep over every base value
        for (int b = 0; b < 256; b++) begin
            wr(1, 8'(b));
            wr(0, 8'h40);
            wr(0, 8'h80);
            tick_src[0] = 1'b1;
            k = 301;
            for (int c = 1; c <= 300; c++) begin
                @(negedge clk);
                if (uflow) begin
                    k = c;
                    break;
                end
            end
            tick_src = '0;
            check("R5 period", k, b + 1);
            rd(2, d); check("R5 reload value", d, b);
            wr(0, 8'h00);
        end

        finish_run();
    end

endmodule